// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Width Converter

This block connects a 36-bit FIFO-side word stream to a narrow port that is 18 bits wide. At run time, the narrow port works either as an 18-bit word bus or as a 9-bit byte bus. Both directions are built in.

- **Read direction (unpacker).** Each 36-bit word taken from the FIFO side is split into a sequence of narrow transfers: two in word mode, four in byte mode.
- **Write direction (packer).** Narrow transfers are gathered into one 36-bit word. That word is offered to the FIFO side only when it is complete.

An endian select fixes the order of the sub-word pieces:

- **Big-endian:** the most significant piece travels first.
- **Little-endian:** the least significant piece travels first.

Every side uses a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high.

The size and endian selects are captured while reset is held. They act as a static configuration until the next reset.

Top module: `bus_width_bridge`

## Requirements
- R1: During and right after reset (rst_n low, synchronous), the outputs are `nar_out_valid`=0, `wide_out_valid`=0, `wide_in_ready`=1 and `nar_in_ready`=1.
- R2: Word mode (`cfg_byte`=0) with big-endian order (`cfg_little`=0): a 36-bit word leaves as bits [35:18] and then bits [17:0] on `nar_out_data`.
- R3: Word mode with little-endian order (`cfg_little`=1): bits [17:0] leave first, then bits [35:18].
- R4: Byte mode (`cfg_byte`=1), big-endian: four transfers carry bits [35:27], [26:18], [17:9] and [8:0], in that order, on `nar_out_data[8:0]`. `nar_out_data[17:9]` reads zero.
- R5: Byte mode, little-endian: the four bytes leave in the order [8:0], [17:9], [26:18], [35:27].
- R6: While `nar_out_valid` is high and `nar_out_ready` is low, `nar_out_valid` stays high and `nar_out_data` does not change.
- R7: The unpacker takes a new wide word only when it is idle, or in the same cycle as the acceptance of the last narrow piece. `wide_in_ready` is low while earlier pieces are still pending.
- R8: Word-mode packing mirrors R2 and R3. In big-endian order, the first accepted piece becomes bits [35:18]. In little-endian order, it becomes bits [17:0].
- R9: Byte-mode packing mirrors R4 and R5 and uses only `nar_in_data[8:0]`. Bits [17:9] are ignored.
- R10: `wide_out_valid` rises only in the cycle after the last piece of a word is accepted. It then holds with stable `wide_out_data` until `wide_out_ready`. `nar_in_ready` is low while it is high.
- R11: `cfg_byte` and `cfg_little` are sampled only while rst_n is low. Changing them after reset does not alter the piece order or the piece count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_byte | input | 1 | 1 = byte (9-bit) narrow transfers, 0 = word (18-bit) |
| cfg_little | input | 1 | 1 = least significant piece first, 0 = most significant first |
| wide_in_data | input | 36 | Word from the FIFO side to be split |
| wide_in_valid | input | 1 | `wide_in_data` is offered |
| wide_in_ready | output | 1 | Unpacker can take a word |
| nar_out_data | output | 18 | Current narrow piece (byte mode uses [8:0]) |
| nar_out_valid | output | 1 | `nar_out_data` holds a piece |
| nar_out_ready | input | 1 | Narrow consumer takes the piece |
| nar_in_data | input | 18 | Narrow piece to be packed (byte mode uses [8:0]) |
| nar_in_valid | input | 1 | `nar_in_data` is offered |
| nar_in_ready | output | 1 | Packer can take a piece |
| wide_out_data | output | 36 | Packed word for the FIFO side |
| wide_out_valid | output | 1 | `wide_out_data` holds a complete word |
| wide_out_ready | input | 1 | FIFO side takes the packed word |

## Verification
The hardest case to reach from the ports is a configuration change after reset. The new select values must have no effect, and a wrong design would only show it through a different piece order. The stimulus resets the block in word/big-endian mode and then drives both selects to the opposite values. It then checks that a word still leaves as two pieces, upper half first. Each table entry resets the block in its own mode, so all four size/endian combinations are covered in both directions. A deliberate consumer stall and a held-back wide-side ready cover the hold behaviour.

// File: rtl/bwb_pkg.sv
// Shared configuration type and piece ordering for the width converter.
// Assumes the wide word splits into exactly four bytes or two halves.
package bwb_pkg;

    typedef struct packed {
        logic byte_mode;   // 1 = four byte pieces, 0 = two half pieces
        logic little;      // 1 = least significant piece first
    } bwb_mode_t;

    localparam int BYTE_PIECES = 4;
    localparam int HALF_PIECES = 2;
    localparam int IDX_W       = $clog2(BYTE_PIECES);

    // Map the transfer number to the lane index (lane 0 = least significant).
    function automatic logic [IDX_W-1:0] lane_of(bwb_mode_t m, logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] top;
        top = m.byte_mode ? IDX_W'(BYTE_PIECES - 1) : IDX_W'(HALF_PIECES - 1);
        return m.little ? k : (top - k);
    endfunction

    // True when the transfer number is the final piece of a word.
    function automatic logic is_last(bwb_mode_t m, logic [IDX_W-1:0] k);
        return m.byte_mode ? (k == IDX_W'(BYTE_PIECES - 1)) : (k == IDX_W'(HALF_PIECES - 1));
    endfunction

endpackage

// File: rtl/bwb_unpacker.sv
// Splits each wide word into two half pieces or four byte pieces on the
// narrow side, in the order given by the mode. Assumes the mode is static
// while out of reset. A new word may be taken in the cycle the last piece
// leaves, so back-to-back words flow without a bubble.
module bwb_unpacker
    import bwb_pkg::*;
#(
    parameter int WIDE_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bwb_mode_t           mode,
    input  logic [WIDE_W-1:0]   win_data,
    input  logic                win_valid,
    output logic                win_ready,
    output logic [WIDE_W/2-1:0] nout_data,
    output logic                nout_valid,
    input  logic                nout_ready
);
    localparam int NW = WIDE_W / 2;
    localparam int BW = WIDE_W / 4;

    logic [WIDE_W-1:0] hold_q;
    logic [IDX_W-1:0]  idx_q;
    logic              busy_q;
    logic              last;
    logic              take;
    logic              give;
    logic [IDX_W-1:0]  lane;

    // Handshake decode for both sides of the unpacker.
    always_comb begin
        last      = is_last(mode, idx_q);
        give      = busy_q && nout_ready;
        win_ready = !busy_q || (give && last);
        take      = win_valid && win_ready;
        lane      = lane_of(mode, idx_q);
    end

    // Select the current piece from the held word.
    always_comb begin
        nout_data = '0;
        if (mode.byte_mode) begin
            nout_data[BW-1:0] = hold_q[lane*BW +: BW];
        end else begin
            nout_data = hold_q[lane[0]*NW +: NW];
        end
        nout_valid = busy_q;
    end

    // Word hold register and piece counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (take) begin
            hold_q <= win_data;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (give) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (nout_valid && !nout_ready) |=> (nout_valid && $stable(nout_data))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ready && nout_valid) |-> nout_ready); // R7

endmodule

// File: rtl/bwb_packer.sv
// Gathers narrow pieces into a wide word in the order given by the mode and
// offers the word only once every piece has arrived. Assumes the mode is
// static while out of reset. New pieces are refused while a word is waiting.
module bwb_packer
    import bwb_pkg::*;
#(
    parameter int WIDE_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bwb_mode_t           mode,
    input  logic [WIDE_W/2-1:0] nin_data,
    input  logic                nin_valid,
    output logic                nin_ready,
    output logic [WIDE_W-1:0]   wout_data,
    output logic                wout_valid,
    input  logic                wout_ready
);
    localparam int NW = WIDE_W / 2;
    localparam int BW = WIDE_W / 4;

    logic [WIDE_W-1:0] acc_q;
    logic [IDX_W-1:0]  idx_q;
    logic              full_q;
    logic              take;
    logic [IDX_W-1:0]  lane;

    // Handshake decode and lane choice.
    always_comb begin
        nin_ready  = !full_q;
        take       = nin_valid && !full_q;
        lane       = lane_of(mode, idx_q);
        wout_valid = full_q;
        wout_data  = acc_q;
    end

    // Accumulator, piece counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (take) begin
            if (mode.byte_mode) begin
                acc_q[lane*BW +: BW] <= nin_data[BW-1:0];
            end else begin
                acc_q[lane[0]*NW +: NW] <= nin_data;
            end
            if (is_last(mode, idx_q)) begin
                idx_q  <= '0;
                full_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (full_q && wout_ready) begin
            full_q <= 1'b0;
        end
    end

    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wout_valid && !wout_ready) |=> (wout_valid && $stable(wout_data))); // R10

    AST_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wout_valid) |-> $past(nin_valid && nin_ready)); // R10

    AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wout_valid |-> !nin_ready); // R10

endmodule

// File: rtl/bus_width_bridge.sv
// Top of the bus-matching converter: captures the size and endian selects
// during reset and feeds them to an unpacker (wide to narrow) and a packer
// (narrow to wide). Assumes rst_n is synchronous to clk.
module bus_width_bridge
    import bwb_pkg::*;
#(
    parameter int WIDE_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_byte,
    input  logic                cfg_little,
    input  logic [WIDE_W-1:0]   wide_in_data,
    input  logic                wide_in_valid,
    output logic                wide_in_ready,
    output logic [WIDE_W/2-1:0] nar_out_data,
    output logic                nar_out_valid,
    input  logic                nar_out_ready,
    input  logic [WIDE_W/2-1:0] nar_in_data,
    input  logic                nar_in_valid,
    output logic                nar_in_ready,
    output logic [WIDE_W-1:0]   wide_out_data,
    output logic                wide_out_valid,
    input  logic                wide_out_ready
);
    bwb_mode_t mode_q;

    // Configuration capture, open only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{byte_mode: cfg_byte, little: cfg_little};
        end
    end

    bwb_unpacker #(.WIDE_W(WIDE_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .win_data   (wide_in_data),
        .win_valid  (wide_in_valid),
        .win_ready  (wide_in_ready),
        .nout_data  (nar_out_data),
        .nout_valid (nar_out_valid),
        .nout_ready (nar_out_ready)
    );

    bwb_packer #(.WIDE_W(WIDE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .nin_data   (nar_in_data),
        .nin_valid  (nar_in_valid),
        .nin_ready  (nar_in_ready),
        .wout_data  (wide_out_data),
        .wout_valid (wide_out_valid),
        .wout_ready (wide_out_ready)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q)); // R11

endmodule

// File: tb/bus_width_bridge_test.sv
`timescale 1ns/100ps
module bus_width_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte = 1'b0, cfg_little = 1'b0;
    logic [35:0] wide_in_data = '0;
    logic        wide_in_valid = 1'b0;
    logic        wide_in_ready;
    logic [17:0] nar_out_data;
    logic        nar_out_valid;
    logic        nar_out_ready = 1'b1;
    logic [17:0] nar_in_data = '0;
    logic        nar_in_valid = 1'b0;
    logic        nar_in_ready;
    logic [35:0] wide_out_data;
    logic        wide_out_valid;
    logic        wide_out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bus_width_bridge uut (.*);

    // Vector table: {byte mode, little endian, word}
    localparam logic [37:0] VEC [8] = '{
        {2'b00, 36'h123456789}, {2'b01, 36'h123456789},
        {2'b10, 36'hFEDCBA987}, {2'b11, 36'hFEDCBA987},
        {2'b00, 36'h800000001}, {2'b01, 36'hAAAA55555},
        {2'b10, 36'h0F0F0F0F0}, {2'b11, 36'h13579BDF2}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected narrow piece k of a word, from R2..R5.
    function automatic logic [17:0] piece(logic [35:0] w, bit b, bit l, int k);
        int n    = b ? 4 : 2;
        int lane = l ? k : n - 1 - k;
        return b ? {9'b0, w[lane*9 +: 9]} : w[lane*18 +: 18];
    endfunction

    function automatic string unpack_tag(bit b, bit l);
        if (!b) return l ? "R3" : "R2";
        return l ? "R5" : "R4";
    endfunction

    task automatic do_reset(input bit b, input bit l);
        rst_n = 1'b0; cfg_byte = b; cfg_little = l;
        repeat (3) @(negedge clk);
        check(!nar_out_valid && !wide_out_valid && wide_in_ready && nar_in_ready, "R1 in reset",
              {nar_out_valid, wide_out_valid, wide_in_ready, nar_in_ready}, 36'h3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!nar_out_valid && !wide_out_valid && wide_in_ready && nar_in_ready, "R1 after reset",
              {nar_out_valid, wide_out_valid, wide_in_ready, nar_in_ready}, 36'h3);
    endtask

    task automatic unpack_run(input logic [35:0] w, input bit b, input bit l, input string tag);
        int n = b ? 4 : 2;
        nar_out_ready = 1'b1;
        wide_in_data  = w;
        wide_in_valid = 1'b1;
        @(negedge clk);
        wide_in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            check(nar_out_valid && nar_out_data == piece(w, b, l, k), tag,
                  {17'b0, nar_out_valid, nar_out_data}, {18'h1, piece(w, b, l, k)});
            if (k == 0)
                check(!wide_in_ready, "R7 ready low mid-word", wide_in_ready, 36'h0);
            @(negedge clk);
        end
        check(!nar_out_valid, {tag, " piece count"}, nar_out_valid, 36'h0);
    endtask

    task automatic pack_run(input logic [35:0] w, input bit b, input bit l);
        int n = b ? 4 : 2;
        string tag = b ? "R9" : "R8";
        wide_out_ready = 1'b0;
        for (int k = 0; k < n; k++) begin
            nar_in_data  = piece(w, b, l, k) | (b ? {9'h1A5, 9'h000} : 18'h0);
            nar_in_valid = 1'b1;
            check(!wide_out_valid, "R10 no early word", wide_out_valid, 36'h0);
            @(negedge clk);
        end
        nar_in_valid = 1'b0;
        check(wide_out_valid && wide_out_data == w, tag, wide_out_data, w);
        check(!nar_in_ready, "R10 input blocked while full", nar_in_ready, 36'h0);
        @(negedge clk);
        check(wide_out_valid && wide_out_data == w, "R10 hold", wide_out_data, w);
        wide_out_ready = 1'b1;
        @(negedge clk);
        check(!wide_out_valid, "R10 released", wide_out_valid, 36'h0);
        wide_out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // Table walk: every mode, both directions.
        foreach (VEC[i]) begin
            do_reset(VEC[i][37], VEC[i][36]);
            unpack_run(VEC[i][35:0], VEC[i][37], VEC[i][36], unpack_tag(VEC[i][37], VEC[i][36]));
            pack_run(VEC[i][35:0], VEC[i][37], VEC[i][36]);
        end

        // R6: consumer stall holds the first piece.
        do_reset(1'b1, 1'b0);
        nar_out_ready = 1'b0;
        wide_in_data  = 36'h9ABCDEF01;
        wide_in_valid = 1'b1;
        @(negedge clk);
        wide_in_valid = 1'b0;
        for (int s = 0; s < 3; s++) begin
            check(nar_out_valid && nar_out_data == piece(36'h9ABCDEF01, 1, 0, 0), "R6 stall",
                  nar_out_data, piece(36'h9ABCDEF01, 1, 0, 0));
            @(negedge clk);
        end
        nar_out_ready = 1'b1;
        for (int k = 0; k < 4; k++) @(negedge clk);
        check(!nar_out_valid, "R6 drain", nar_out_valid, 36'h0);

        // R7: back-to-back words without a bubble.
        do_reset(1'b0, 1'b0);
        wide_in_data  = 36'h111122222;
        wide_in_valid = 1'b1;
        @(negedge clk);
        wide_in_data  = 36'h333344444;
        check(!wide_in_ready, "R7 busy first piece", wide_in_ready, 36'h0);
        @(negedge clk);
        check(wide_in_ready, "R7 ready on last piece", wide_in_ready, 36'h1);
        @(negedge clk);
        wide_in_valid = 1'b0;
        check(nar_out_valid && nar_out_data == 18'(36'h333344444 >> 18), "R7 next word first piece",
              nar_out_data, 36'h333344444 >> 18);

        // R11: selects changed after reset have no effect.
        do_reset(1'b0, 1'b0);
        cfg_byte = 1'b1; cfg_little = 1'b1;
        @(negedge clk);
        unpack_run(36'h2468ACE13, 1'b0, 1'b0, "R11 unpack");
        pack_run(36'h2468ACE13, 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule